// File: doc/BRIEF.md
# Bidirectional DDR Pad Register

This block is a vendor-neutral model of the double-data-rate registers that sit next to a bidirectional bus pin. It has a transmit side and a receive side, and each side runs on its own clock.

On the transmit side, core logic presents two words and a drive request. All three are captured on the rising edge of the transmit clock. The first word is driven onto the pad for the high half of the clock. The second word is driven for the low half, starting at the falling edge. When the drive request is low, the pad floats so that an external device can drive it.

On the receive side, the pad is sampled on the falling edge and again on the next rising edge of the receive clock. The two samples are handed to core logic together, aligned to that rising edge.

Each side has its own clock enable and its own synchronous reset. The pad width is a parameter.

Top module: `ddr_pad_reg`

## Requirements
- R1: On a rising edge of `tx_clk` with `tx_ce` high and `tx_rst` low, `tx_word_a`, `tx_word_b` and `tx_drive` are captured into the transmit registers.
- R2: While the captured drive flag is 1, the pad carries the captured first word (`tx_word_a`) from the capturing rising edge until the next falling edge of `tx_clk`.
- R3: While the captured drive flag is 1, the pad carries the captured second word (`tx_word_b`) from the falling edge of `tx_clk` until the next rising edge.
- R4: While the captured drive flag is 0, the block does not drive the pad, and the pad shows the value of any external driver.
- R5: A rising edge of `tx_clk` with `tx_rst` high clears the drive flag and both transmit words. A rising edge of `rx_clk` with `rx_rst` high clears `rx_word_rise` and `rx_word_fall`. The falling-edge sample is also cleared while `rx_rst` is high.
- R6: On a rising edge of `rx_clk` with `rx_ce` high, `rx_word_rise` takes the pad value sampled at that rising edge.
- R7: On the same rising edge, `rx_word_fall` takes the pad value sampled at the falling edge of `rx_clk` immediately before it. Both receive words update together.
- R8: While `tx_ce` is low, the transmit words and the drive flag keep their values on rising edges of `tx_clk`.
- R9: While `rx_ce` is low, the falling-edge sample and both receive words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock |
| tx_rst | input | 1 | Synchronous reset, transmit side, active high |
| tx_ce | input | 1 | Transmit clock enable |
| tx_drive | input | 1 | Drive request, active high |
| tx_word_a | input | WIDTH | Word driven in the high phase |
| tx_word_b | input | WIDTH | Word driven in the low phase |
| rx_clk | input | 1 | Receive clock |
| rx_rst | input | 1 | Synchronous reset, receive side, active high |
| rx_ce | input | 1 | Receive clock enable |
| rx_word_rise | output | WIDTH | Pad sample from the rising edge |
| rx_word_fall | output | WIDTH | Pad sample from the preceding falling edge |
| pad | inout | WIDTH | Bidirectional bus pin |

## Verification
The receive clock lags the transmit clock by a quarter period, so every receive edge falls in the middle of a transmit half-cycle. With the drive request on, random word pairs loop back through the pad. This shows whether the high-phase word and the low-phase word reach their own receive words, or come out swapped or shifted by a cycle. With the drive request off, a bench driver places a fresh value on the pad in each half-cycle. This shows the block releasing the pad, and shows which falling sample is paired with which rising sample. Enables held low on each side, and resets applied in the middle of the run, separate holding from capturing and from clearing.

// File: rtl/ddr_pad_reg.sv
`timescale 1ns/1ps
module ddr_pad_reg #(
  parameter int WIDTH = 8
) (
  input  logic             tx_clk,
  input  logic             tx_rst,
  input  logic             tx_ce,
  input  logic             tx_drive,
  input  logic [WIDTH-1:0] tx_word_a,
  input  logic [WIDTH-1:0] tx_word_b,
  input  logic             rx_clk,
  input  logic             rx_rst,
  input  logic             rx_ce,
  output logic [WIDTH-1:0] rx_word_rise,
  output logic [WIDTH-1:0] rx_word_fall,
  inout  wire  [WIDTH-1:0] pad
);
  logic             oe_q;
  logic [WIDTH-1:0] a_q, b_q, b_late;
  logic [WIDTH-1:0] fall_s;

  always_ff @(posedge tx_clk) begin
    if (tx_rst) begin
      oe_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (tx_ce) begin
      oe_q <= tx_drive;
      a_q  <= tx_word_a;
      b_q  <= tx_word_b;
    end
  end

  always_ff @(negedge tx_clk) b_late <= b_q;

  assign pad = oe_q ? (tx_clk ? a_q : b_late) : {WIDTH{1'bz}};

  always_ff @(negedge rx_clk) begin
    if (rx_rst)     fall_s <= '0;
    else if (rx_ce) fall_s <= pad;
  end

  always_ff @(posedge rx_clk) begin
    if (rx_rst) begin
      rx_word_rise <= '0;
      rx_word_fall <= '0;
    end else if (rx_ce) begin
      rx_word_rise <= pad;
      rx_word_fall <= fall_s;
    end
  end
endmodule

module ddr_pad_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             tx_clk,
  input logic             tx_rst,
  input logic             tx_ce,
  input logic             tx_drive,
  input logic             oe_q,
  input logic             rx_clk,
  input logic             rx_rst,
  input logic             rx_ce,
  input logic [WIDTH-1:0] pad,
  input logic [WIDTH-1:0] rx_word_rise,
  input logic [WIDTH-1:0] rx_word_fall
);
  // R1
  drive_capture_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
    tx_ce |=> oe_q == $past(tx_drive));
  // R8
  drive_hold_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
    !tx_ce |=> $stable(oe_q));
  // R6
  rise_sample_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_ce |=> rx_word_rise == $past(pad));
  // R9
  rx_hold_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
    !rx_ce |=> $stable(rx_word_rise) && $stable(rx_word_fall));
endmodule

bind ddr_pad_reg ddr_pad_reg_chk #(.WIDTH(WIDTH)) chk_i (
  .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_ce(tx_ce), .tx_drive(tx_drive),
  .oe_q(oe_q), .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_ce(rx_ce),
  .pad(pad), .rx_word_rise(rx_word_rise), .rx_word_fall(rx_word_fall)
);

// File: tb/ddr_pad_reg_tb.sv
`timescale 1ns/1ps
module ddr_pad_reg_tb_top;
  localparam int W = 8;

  logic tx_clk = 1'b0, rx_clk = 1'b0;
  logic tx_rst = 1'b1, tx_ce = 1'b0, tx_drive = 1'b0;
  logic rx_rst = 1'b1, rx_ce = 1'b0;
  logic [W-1:0] tx_word_a = '0, tx_word_b = '0;
  logic [W-1:0] rx_word_rise, rx_word_fall;
  logic [W-1:0] ext_val = 8'h3c;
  logic ext_en = 1'b1;
  wire  [W-1:0] pad;

  assign pad = ext_en ? ext_val : {W{1'bz}};

  always #2.5 tx_clk = ~tx_clk;
  initial begin
    #1.25;
    forever #2.5 rx_clk = ~rx_clk;
  end

  ddr_pad_reg #(.WIDTH(W)) dut_i (
    .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_ce(tx_ce), .tx_drive(tx_drive),
    .tx_word_a(tx_word_a), .tx_word_b(tx_word_b),
    .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_ce(rx_ce),
    .rx_word_rise(rx_word_rise), .rx_word_fall(rx_word_fall), .pad(pad)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Reference model, transmit side
  logic         oe_m = 1'b0;
  logic [W-1:0] a_m = '0, b_m = '0;
  always @(posedge tx_clk) begin
    if (tx_rst) begin
      oe_m = 1'b0; a_m = '0; b_m = '0;
    end else if (tx_ce) begin
      oe_m = tx_drive; a_m = tx_word_a; b_m = tx_word_b;
    end
    #0.1 ext_en = !oe_m;
    #0.9;
    if (oe_m) check(pad, a_m, "R2 high-phase word");
    else      check(pad, ext_val, "R4/R5 released in high phase");
  end
  always @(negedge tx_clk) begin
    #1.0;
    if (oe_m) check(pad, b_m, "R3 low-phase word");
    else      check(pad, ext_val, "R4 released in low phase");
  end

  // Reference model, receive side
  logic [W-1:0] fall_m = '0, rise_q = '0, fall_q = '0;
  always @(negedge rx_clk) begin
    if (rx_rst)     fall_m = '0;
    else if (rx_ce) fall_m = pad;
  end
  always @(posedge rx_clk) begin
    if (rx_rst) begin
      rise_q = '0; fall_q = '0;
    end else if (rx_ce) begin
      rise_q = pad; fall_q = fall_m;
    end
    #1.0;
    check(rx_word_rise, rise_q, "R6/R5/R9 rising sample");
    check(rx_word_fall, fall_q, "R7/R5/R9 falling sample");
  end

  task automatic cyc(input bit drv, input bit tce, input bit trst,
                     input bit rce, input bit rrst);
    @(posedge tx_clk);
    #0.3;
    ext_val = W'($urandom);
    rx_ce = rce; rx_rst = rrst;
    #2.7;
    ext_val = W'($urandom);
    tx_word_a = W'($urandom); tx_word_b = W'($urandom);
    tx_drive = drv; tx_ce = tce; tx_rst = trst;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 1);
    // reset state: R5
    check(rx_word_rise, '0, "R5 reset rx rise");
    check(rx_word_fall, '0, "R5 reset rx fall");
    // external driver, receive pairing: R4 R6 R7
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 1, 0);
    // loopback: R1 R2 R3
    for (int i = 0; i < 60; i++) cyc(1, 1, 0, 1, 0);
    // transmit enable low holds: R8
    for (int i = 0; i < 20; i++) cyc(i[0], (i % 4) == 0, 0, 1, 0);
    // receive enable gaps: R9
    for (int i = 0; i < 40; i++) cyc(1, 1, 0, (i % 3) != 0, 0);
    // random drive toggling
    for (int i = 0; i < 60; i++) cyc($urandom_range(0, 1) == 1, 1, 0, 1, 0);
    // mid-run resets: R5
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 1);
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule